// File: doc/BRIEF.md
# Oversampling Serial Receiver with Majority Vote

This block receives asynchronous serial frames of ten bits: a low start bit, eight data bits with the least significant bit first, and a stop bit. The serial line is first passed through a two-flop synchronizer. It is then observed once per pulse of an external tick that runs at sixteen times the bit rate. A falling edge on the line starts a frame, and the sixteen-state bit counter is realigned to that edge. The level of each bit is decided by a two-of-three vote over three samples taken near the middle of the bit. If the start bit does not vote low, the frame is abandoned and the receiver goes back to waiting for an edge.

A nine-bit shift register is preset to all ones at the edge. Bits enter it at the right. When the zero of the start bit reaches the leftmost position, the current bit is the stop bit, and the frame is finished. The byte and the stop bit are written to the output registers, and the done flag is raised, only when done is low at that moment. The multiprocessor gate adds one more condition: if the gate is high, the stop bit must also be 1. A frame that fails these conditions is dropped. In every case the receiver then returns to edge search. The host clears done with a one-cycle pulse.

Top module: `uart_vote_rx`

## Requirements
- R1: After reset, done, data_out and stop_out are all 0.
- R2: Edge search runs only while rx_en is 1 and no frame is in progress. A frame sent while rx_en is 0 leaves done, data_out and stop_out unchanged.
- R3: The tick on which the falling edge is seen is counter state 0. The line is sampled at states 7, 8 and 9 of each bit time, and the bit value is the majority of those three samples. A one-tick glitch inside any bit does not change the received byte.
- R4: If the start bit votes 1, the receiver returns to edge search. A valid frame that follows is then received correctly.
- R5: The first data bit received becomes data_out[0] and the last becomes data_out[7]. The voted stop bit goes to stop_out. Both are loaded at the end of the stop bit's time (tick state 15), and done rises in the same clock.
- R6: A frame that completes while done is 1 is dropped: data_out and stop_out keep their earlier values.
- R7: While mp_mode is 1, a frame whose stop bit is 0 is dropped. A frame whose stop bit is 1 is loaded.
- R8: done stays 1 until a done_clr pulse, and then falls. data_out and stop_out change only in a clock where done rises.
- R9: While mp_mode is 0, a frame with a stop bit of 0 is still loaded, and stop_out reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-clock enable pulse at 16x the bit rate |
| rx_en | input | 1 | Allows edge search |
| mp_mode | input | 1 | Multiprocessor gate: when 1, frames must end with a stop bit of 1 |
| done_clr | input | 1 | Host pulse that clears done |
| rxd | input | 1 | Asynchronous serial line, idle high |
| data_out | output | 8 | Last accepted byte |
| stop_out | output | 1 | Stop bit of the last accepted frame |
| done | output | 1 | A frame has been accepted and not yet cleared |

## Verification
The assertions hold on every cycle. They check the persistence of done, that it falls only after a done_clr pulse, that the output registers move only when done rises, and that a load under the multiprocessor gate always carries a stop bit of 1. Some behaviours show only in the bench's scenarios, because they depend on a whole frame's worth of line timing. These are the majority vote against a glitch, the rejection of a short false start, the bit order over every byte value, and the frames that are dropped while done is set or while rx_en is low.

// File: rtl/uart_vote_rx.sv
module uart_vote_rx #(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx_en,
  input  logic       mp_mode,
  input  logic       done_clr,
  input  logic       rxd,
  output logic [7:0] data_out,
  output logic       stop_out,
  output logic       done
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] S_A   = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] S_B   = CW'(OVERSAMPLE / 2);
  localparam logic [CW-1:0] S_C   = CW'(OVERSAMPLE / 2 + 1);
  localparam logic [CW-1:0] S_END = CW'(OVERSAMPLE - 1);

  logic [1:0]    sync_q;
  logic          line_q;
  logic          busy;
  logic [CW-1:0] cnt;
  logic [2:0]    smp;
  logic [8:0]    sh;
  logic [7:0]    byte_rev;

  wire rx_s    = sync_q[1];
  wire vote    = (smp[0] & smp[1]) | (smp[0] & smp[2]) | (smp[1] & smp[2]);
  wire start   = !busy && rx_en && tick16 && line_q && !rx_s;
  wire bit_end = busy && tick16 && (cnt == S_END);
  wire first   = &sh;
  wire last    = !sh[8];
  wire accept  = bit_end && last && !done && (!mp_mode || vote);

  always_comb
    for (int i = 0; i < 8; i++) byte_rev[i] = sh[7-i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      line_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], rxd};
      if (tick16) line_q <= rx_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      smp  <= '1;
      sh   <= '1;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(1);
      sh   <= 9'h1FF;
    end else if (busy && tick16) begin
      cnt <= cnt + 1'b1;
      if (cnt == S_A) smp[0] <= rx_s;
      if (cnt == S_B) smp[1] <= rx_s;
      if (cnt == S_C) smp[2] <= rx_s;
      if (bit_end) begin
        if ((first && vote) || last) busy <= 1'b0;
        else sh <= {sh[7:0], vote};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out <= '0;
      stop_out <= 1'b0;
      done     <= 1'b0;
    end else if (accept) begin
      data_out <= byte_rev;
      stop_out <= vote;
      done     <= 1'b1;
    end else if (done_clr) begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_vote_rx_chk.sv
module uart_vote_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mp_mode,
  input logic       done_clr,
  input logic [7:0] data_out,
  input logic       stop_out,
  input logic       done
);
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_clr |=> done);

  // R8
  done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(done_clr));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done) |-> $stable(data_out));

  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done) |-> $stable(stop_out));

  // R7
  mp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && $past(mp_mode) |-> stop_out);
endmodule

bind uart_vote_rx uart_vote_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mp_mode(mp_mode), .done_clr(done_clr),
  .data_out(data_out), .stop_out(stop_out), .done(done)
);

// File: tb/uart_vote_rx_bench.sv
module uart_vote_rx_bench;
  localparam int BITCLK = 32;

  logic clk = 0, rst_n = 0, tick16 = 0, rx_en = 1, mp_mode = 0, done_clr = 0, rxd = 1;
  logic [7:0] data_out;
  logic stop_out, done;
  int total = 0, bad = 0;

  uart_vote_rx u_uart_vote_rx (.*);

  always #5 clk = ~clk;
  initial forever begin @(negedge clk); tick16 = ~tick16; end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stp, input int glitch_bit);
    hold(1'b0, BITCLK);
    for (int i = 0; i < 8; i++) begin
      if (i == glitch_bit) begin
        hold(b[i], 16); hold(~b[i], 2); hold(b[i], BITCLK - 18);
      end else hold(b[i], BITCLK);
    end
    hold(stp, BITCLK);
    hold(1'b1, 24);
  endtask

  task automatic clr;
    done_clr = 1; @(negedge clk); done_clr = 0; @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1", done, 0); chk("R1", data_out, 0); chk("R1", stop_out, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R5 sweep of all byte values
    for (int v = 0; v < 256; v++) begin
      send(8'(v), 1'b1, 9);
      chk("R5", {done, stop_out, data_out}, {2'b11, 8'(v)});
      clr();
      chk("R8", done, 0);
    end

    // R9
    send(8'h3C, 1'b0, 9);
    chk("R9", {done, stop_out, data_out}, {2'b10, 8'h3C});
    clr();

    // R7
    mp_mode = 1;
    send(8'hA5, 1'b0, 9);
    chk("R7", {done, stop_out, data_out}, {2'b00, 8'h3C});
    send(8'hA5, 1'b1, 9);
    chk("R7", {done, stop_out, data_out}, {2'b11, 8'hA5});
    mp_mode = 0;

    // R6 and R8
    send(8'h5A, 1'b0, 9);
    chk("R6", {done, stop_out, data_out}, {2'b11, 8'hA5});
    repeat (40) @(negedge clk);
    chk("R8", done, 1);
    clr();

    // R3 glitch in several bits
    for (int g = 0; g < 8; g += 3) begin
      send(8'hC6, 1'b1, g);
      chk("R3", {done, data_out}, {1'b1, 8'hC6});
      clr();
    end

    // R4 false start then a real frame
    hold(1'b0, 8); hold(1'b1, 3 * BITCLK);
    chk("R4", done, 0);
    send(8'h81, 1'b1, 9);
    chk("R4", {done, data_out}, {1'b1, 8'h81});
    clr();

    // R2
    rx_en = 0;
    send(8'h00, 1'b1, 9);
    chk("R2", {done, data_out}, {1'b0, 8'h81});
    rx_en = 1;
    hold(1'b1, 8);
    send(8'h7E, 1'b1, 9);
    chk("R2", {done, data_out}, {1'b1, 8'h7E});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule